// File: doc/BRIEF.md
# HDMI TMDS Period Encoder

This block turns one HDMI link's per-clock payload into the three 10-bit characters carried on the TMDS data channels, one character per channel per TMDS clock. Each cycle the caller selects a period (control, video or data island) and supplies a 24-bit pixel, three 4-bit packet nibbles, three 2-bit control values and a guard-band request. The encoder applies the coding that matches the period: transition-minimized 8b/10b with a running disparity per channel for video, TERC4 for data islands, and fixed control characters for control periods. A guard-band request replaces the data of a video or island cycle with the matching guard character.

The block enforces the rule that a control period must separate any two non-control periods. If the caller asks to go directly from video to island, or from island to video, the encoder emits one control cycle in place of the requested data and sets a sticky error flag. The data of that cycle is dropped, not deferred. Every character appears exactly two clocks after its inputs are presented, whatever the period.

The period tracker is a three-state machine. Its states are ST_CTL, ST_VID and ST_ISL, held as a `period_t` value. The named transitions are:
- T_OPEN_VID: ST_CTL to ST_VID.
- T_OPEN_ISL: ST_CTL to ST_ISL.
- T_CLOSE: ST_VID or ST_ISL to ST_CTL on request.
- T_HOLD: the state stays as it is.
- T_FORCE_CTL: ST_VID to ST_CTL when island is requested, or ST_ISL to ST_CTL when video is requested. This transition marks an inserted cycle.

Top module: `tmds_period_encoder`

## Requirements
- R1: After reset, each channel outputs 1101010100 (control value 00), and `proto_err` is 0.
- R2: In a control cycle, channel k outputs the code for `ctl_in[2k+1:2k]`. The codes are 00→1101010100, 01→0010101011, 10→0101010100 and 11→1010101011, written from bit 9 down to bit 0. Channel k occupies `tmds_out[10k+9:10k]`.
- R3: In a video cycle, channel k encodes `pixel_in[8k+7:8k]` in two steps. First it forms q_m by XNOR chaining when the byte has more than four ones, or exactly four ones with bit 0 clear, and by XOR chaining otherwise; q_m[8] is 1 for XOR. Then it inverts bits 7:0 (setting bit 9) or not, following the standard balance rules against a signed running disparity. The disparity is updated per channel.
- R4: Any cycle whose effective period is not video clears every channel's running disparity to zero. A video guard cycle leaves the disparity unchanged.
- R5: In an island cycle, channel k emits the TERC4 code of `nib_in[4k+3:4k]`. The codes for nibbles 0 to 15 are: 1010011100, 1001100011, 1011100100, 1011100010, 0101110001, 0100011110, 0110001110, 0100111100, 1011001100, 0100111001, 0110011100, 1011000110, 1010001110, 1001110001, 0101100011, 1011000011.
- R6: With `guard_req` high in a video cycle, channels 0 and 2 output 1011001100 and channel 1 outputs 0100110011. With `guard_req` high in an island cycle, all channels output 0100110011.
- R7: `guard_req` has no effect in a control cycle.
- R8: A request for island directly after a video cycle, or for video directly after an island cycle, yields one control cycle using that cycle's `ctl_in`. The requested data is dropped. `proto_err` rises together with that inserted character and stays high until reset.
- R9: Transitions that pass through at least one control cycle never set `proto_err`.
- R10: Every character reaches `tmds_out` two clock edges after the inputs that produced it are sampled, in all periods.
- R11: `period_sel` encodes 0 as control, 1 as video and 2 as island. The value 3 is treated as control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TMDS character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Requested period: 0 control, 1 video, 2 island, 3 control |
| pixel_in | input | 24 | Video bytes, byte k for channel k |
| nib_in | input | 12 | Island nibbles, nibble k for channel k |
| ctl_in | input | 6 | Control values, pair k for channel k |
| guard_req | input | 1 | Emit a guard character instead of data |
| tmds_out | output | 30 | Three 10-bit characters, channel k in bits 10k+9:10k |
| proto_err | output | 1 | Sticky flag for a missing control separator |

## Verification
The bench drives all 256 byte values through each video channel. It checks that the disparity carries across guard cycles, so an encoder that reset or advanced it there would diverge on the following characters. It also checks that the disparity restarts after a control cycle, so an encoder that kept its old balance would pick the wrong inversion on the first new pixel. Every TERC4 nibble and every control combination is swept per channel. The direct video-to-island and island-to-video requests are exercised to confirm three things: exactly one control character is inserted, the dropped data never appears, and the flag stays high. An encoder that deferred the data, skipped the insertion, or let the flag fall would show mismatched characters one cycle later. A single video cycle between control cycles pins the two-cycle latency.

// File: rtl/tmds_pkg.sv
package tmds_pkg;

    typedef enum logic [1:0] {
        PER_CTL = 2'd0,
        PER_VID = 2'd1,
        PER_ISL = 2'd2
    } period_t;

    localparam logic [9:0] GUARD_A = 10'b1011001100;
    localparam logic [9:0] GUARD_B = 10'b0100110011;

    function automatic logic [9:0] ctl_char(input logic [1:0] c);
        logic [9:0] r;
        unique case (c)
            2'b00: r = 10'b1101010100;
            2'b01: r = 10'b0010101011;
            2'b10: r = 10'b0101010100;
            default: r = 10'b1010101011;
        endcase
        return r;
    endfunction

    function automatic logic [9:0] terc4_char(input logic [3:0] n);
        logic [9:0] r;
        unique case (n)
            4'h0: r = 10'b1010011100;
            4'h1: r = 10'b1001100011;
            4'h2: r = 10'b1011100100;
            4'h3: r = 10'b1011100010;
            4'h4: r = 10'b0101110001;
            4'h5: r = 10'b0100011110;
            4'h6: r = 10'b0110001110;
            4'h7: r = 10'b0100111100;
            4'h8: r = 10'b1011001100;
            4'h9: r = 10'b0100111001;
            4'hA: r = 10'b0110011100;
            4'hB: r = 10'b1011000110;
            4'hC: r = 10'b1010001110;
            4'hD: r = 10'b1001110001;
            4'hE: r = 10'b0101100011;
            default: r = 10'b1011000011;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmds_period_fsm.sv
module tmds_period_fsm
    import tmds_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           req_sel,
    input  logic [8*LANES-1:0]   pix_in,
    input  logic [4*LANES-1:0]   nib_in,
    input  logic [2*LANES-1:0]   ctl_in,
    input  logic                 guard_in,
    output period_t              per_q,
    output logic [8*LANES-1:0]   pix_q,
    output logic [4*LANES-1:0]   nib_q,
    output logic [2*LANES-1:0]   ctl_q,
    output logic                 guard_q,
    output logic                 ins_q
);

    period_t req_per;
    period_t per_n;
    logic    ins_n;

    // decode request and pick next state
    always_comb begin
        unique case (req_sel)
            2'd1:    req_per = PER_VID;
            2'd2:    req_per = PER_ISL;
            default: req_per = PER_CTL;
        endcase
        per_n = req_per;
        ins_n = 1'b0;
        unique case (per_q)
            PER_VID: begin
                if (req_per == PER_ISL) begin
                    per_n = PER_CTL;
                    ins_n = 1'b1;
                end
            end
            PER_ISL: begin
                if (req_per == PER_VID) begin
                    per_n = PER_CTL;
                    ins_n = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= PER_CTL;
            ins_q <= 1'b0;
        end else begin
            per_q <= per_n;
            ins_q <= ins_n;
        end
    end

    // payload register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q   <= '0;
            nib_q   <= '0;
            ctl_q   <= '0;
            guard_q <= 1'b0;
        end else begin
            pix_q   <= pix_in;
            nib_q   <= nib_in;
            ctl_q   <= ctl_in;
            guard_q <= guard_in;
        end
    end

    assert_sep_vid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == PER_VID) |=> (per_q != PER_ISL));
    assert_sep_isl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == PER_ISL) |=> (per_q != PER_VID));
    assert_insert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == PER_VID && req_sel == 2'd2) |=> (ins_q && per_q == PER_CTL));

endmodule

// File: rtl/tmds_lane.sv
module tmds_lane
    import tmds_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int DISP_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  period_t    per,
    input  logic [7:0] vdat,
    input  logic [3:0] nib,
    input  logic [1:0] ctl,
    input  logic       guard,
    output logic [9:0] char_q
);

    localparam logic [9:0] VID_GUARD = (LANE == 1) ? GUARD_B : GUARD_A;
    localparam logic signed [DISP_W-1:0] TWO = DISP_W'(2);

    logic signed [DISP_W-1:0] disp_q, disp_v, disp_n, bal;
    logic [3:0] ones_d, ones_q;
    logic [8:0] qm;
    logic       use_xnor, disp_pos, disp_neg, bal_pos, bal_neg;
    logic [9:0] vid_char, char_n;

    // transition-minimized stage and balance decision
    always_comb begin
        ones_d = '0;
        for (int i = 0; i < 8; i++) ones_d = ones_d + 4'(vdat[i]);
        use_xnor = (ones_d > 4'd4) || (ones_d == 4'd4 && !vdat[0]);
        qm[0] = vdat[0];
        for (int i = 1; i < 8; i++)
            qm[i] = use_xnor ? ~(qm[i-1] ^ vdat[i]) : (qm[i-1] ^ vdat[i]);
        qm[8] = ~use_xnor;
        ones_q = '0;
        for (int i = 0; i < 8; i++) ones_q = ones_q + 4'(qm[i]);
        bal = $signed(DISP_W'({ones_q, 1'b0})) - $signed(DISP_W'(5'd8));
        disp_neg = disp_q[DISP_W-1];
        disp_pos = !disp_neg && (disp_q != '0);
        bal_neg  = bal[DISP_W-1];
        bal_pos  = !bal_neg && (bal != '0);
        if (disp_q == '0 || bal == '0) begin
            vid_char = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
            disp_v   = qm[8] ? disp_q + bal : disp_q - bal;
        end else if ((disp_pos && bal_pos) || (disp_neg && bal_neg)) begin
            vid_char = {1'b1, qm[8], ~qm[7:0]};
            disp_v   = disp_q + (qm[8] ? TWO : '0) - bal;
        end else begin
            vid_char = {1'b0, qm[8], qm[7:0]};
            disp_v   = disp_q - (qm[8] ? '0 : TWO) + bal;
        end
    end

    // character select per period
    always_comb begin
        unique case (per)
            PER_VID: begin
                char_n = guard ? VID_GUARD : vid_char;
                disp_n = guard ? disp_q : disp_v;
            end
            PER_ISL: begin
                char_n = guard ? GUARD_B : terc4_char(nib);
                disp_n = '0;
            end
            default: begin
                char_n = ctl_char(ctl);
                disp_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_q <= 10'b1101010100;
            disp_q <= '0;
        end else begin
            char_q <= char_n;
            disp_q <= disp_n;
        end
    end

    assert_disp_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (per != PER_VID) |=> (disp_q == '0));
    assert_ctl_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (per == PER_CTL) |=> (char_q == 10'b1101010100 || char_q == 10'b0010101011 ||
                              char_q == 10'b0101010100 || char_q == 10'b1010101011));

endmodule

// File: rtl/tmds_period_encoder.sv
module tmds_period_encoder
    import tmds_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int DISP_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            period_sel,
    input  logic [8*LANES-1:0]    pixel_in,
    input  logic [4*LANES-1:0]    nib_in,
    input  logic [2*LANES-1:0]    ctl_in,
    input  logic                  guard_req,
    output logic [10*LANES-1:0]   tmds_out,
    output logic                  proto_err
);

    period_t                per_s;
    logic [8*LANES-1:0]     pix_s;
    logic [4*LANES-1:0]     nib_s;
    logic [2*LANES-1:0]     ctl_s;
    logic                   guard_s;
    logic                   ins_s;

    tmds_period_fsm #(.LANES(LANES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_sel  (period_sel),
        .pix_in   (pixel_in),
        .nib_in   (nib_in),
        .ctl_in   (ctl_in),
        .guard_in (guard_req),
        .per_q    (per_s),
        .pix_q    (pix_s),
        .nib_q    (nib_s),
        .ctl_q    (ctl_s),
        .guard_q  (guard_s),
        .ins_q    (ins_s)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tmds_lane #(.LANE(g), .DISP_W(DISP_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .per    (per_s),
            .vdat   (pix_s[8*g +: 8]),
            .nib    (nib_s[4*g +: 4]),
            .ctl    (ctl_s[2*g +: 2]),
            .guard  (guard_s),
            .char_q (tmds_out[10*g +: 10])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= proto_err | ins_s;
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    assert_err_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_s |=> proto_err);

endmodule

// File: tb/tmds_period_encoder_test.sv
module tmds_period_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  period_sel = 2'd0;
    logic [23:0] pixel_in = '0;
    logic [11:0] nib_in = '0;
    logic [5:0]  ctl_in = '0;
    logic        guard_req = 1'b0;
    logic [29:0] tmds_out;
    logic        proto_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmds_period_encoder uut (
        .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .pixel_in(pixel_in),
        .nib_in(nib_in), .ctl_in(ctl_in), .guard_req(guard_req),
        .tmds_out(tmds_out), .proto_err(proto_err)
    );

    // bench model state
    int md[3];
    int mst = 0;
    bit merr = 0;
    logic [29:0] e0, e1;
    logic ee0, ee1;
    string t0, t1;
    bit v0 = 0, v1 = 0;

    function automatic logic [9:0] m_ctl(input logic [1:0] c);
        case (c)
            2'b00: return 10'b1101010100;
            2'b01: return 10'b0010101011;
            2'b10: return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic logic [9:0] m_terc(input logic [3:0] n);
        case (n)
            0: return 10'b1010011100;  1: return 10'b1001100011;
            2: return 10'b1011100100;  3: return 10'b1011100010;
            4: return 10'b0101110001;  5: return 10'b0100011110;
            6: return 10'b0110001110;  7: return 10'b0100111100;
            8: return 10'b1011001100;  9: return 10'b0100111001;
            10: return 10'b0110011100; 11: return 10'b1011000110;
            12: return 10'b1010001110; 13: return 10'b1001110001;
            14: return 10'b0101100011; default: return 10'b1011000011;
        endcase
    endfunction

    function automatic logic [9:0] m_video(input int ch, input logic [7:0] d);
        int n1 = 0;
        int b = 0;
        bit xn;
        logic [8:0] q;
        logic [9:0] r;
        for (int i = 0; i < 8; i++) n1 += int'(d[i]);
        xn = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
        q[0] = d[0];
        for (int i = 1; i < 8; i++) q[i] = xn ? ~(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
        q[8] = !xn;
        for (int i = 0; i < 8; i++) b += q[i] ? 1 : -1;
        if (md[ch] == 0 || b == 0) begin
            r = {~q[8], q[8], q[8] ? q[7:0] : ~q[7:0]};
            md[ch] += q[8] ? b : -b;
        end else if ((md[ch] > 0 && b > 0) || (md[ch] < 0 && b < 0)) begin
            r = {1'b1, q[8], ~q[7:0]};
            md[ch] += 2 * int'(q[8]) - b;
        end else begin
            r = {1'b0, q[8], q[7:0]};
            md[ch] += b - 2 * (1 - int'(q[8]));
        end
        return r;
    endfunction

    task automatic mstep(input logic [1:0] p, input logic [23:0] px, input logic [11:0] nb,
                         input logic [5:0] c, input logic g,
                         output logic [29:0] e, output logic er);
        int req = (p == 2'd1) ? 1 : (p == 2'd2) ? 2 : 0;
        int eff = req;
        if ((mst == 1 && req == 2) || (mst == 2 && req == 1)) begin
            eff = 0;
            merr = 1;
        end
        mst = eff;
        for (int ch = 0; ch < 3; ch++) begin
            if (eff == 1)
                e[10*ch +: 10] = g ? ((ch == 1) ? 10'b0100110011 : 10'b1011001100)
                                   : m_video(ch, px[8*ch +: 8]);
            else if (eff == 2)
                e[10*ch +: 10] = g ? 10'b0100110011 : m_terc(nb[4*ch +: 4]);
            else
                e[10*ch +: 10] = m_ctl(c[2*ch +: 2]);
        end
        if (eff != 1) for (int ch = 0; ch < 3; ch++) md[ch] = 0;
        er = merr;
    endtask

    task automatic chk(input string tag, input logic [29:0] act, input logic [29:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // one cycle: check output of two cycles ago, then drive new inputs
    task automatic cyc(input logic [1:0] p, input logic [23:0] px, input logic [11:0] nb,
                       input logic [5:0] c, input logic g, input string tag);
        logic [29:0] e;
        logic er;
        @(negedge clk);
        if (v1) begin
            chk(t1, tmds_out, e1);
            chk(ee1 ? "R8" : "R9", {29'd0, proto_err}, {29'd0, ee1});
        end
        e1 = e0; ee1 = ee0; t1 = t0; v1 = v0;
        mstep(p, px, nb, c, g, e, er);
        e0 = e; ee0 = er; t0 = tag; v0 = 1;
        period_sel = p; pixel_in = px; nib_in = nb; ctl_in = c; guard_req = g;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < 3; ch++) md[ch] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", tmds_out, {3{10'b1101010100}});
        chk("R1", {29'd0, proto_err}, 30'd0);
        // R2 all control combinations
        for (int i = 0; i < 64; i++) cyc(2'd0, 24'h0, 12'h0, 6'(i), 1'b0, "R2");
        // R11 select value 3 acts as control
        for (int i = 0; i < 8; i++) cyc(2'd3, 24'hFFFFFF, 12'hFFF, 6'(i * 7), 1'b0, "R11");
        // R3 video sweep, all bytes on each channel
        for (int i = 0; i < 256; i++)
            cyc(2'd1, {8'(i * 37 + 11), 8'(255 - i), 8'(i)}, 12'h0, 6'h0, 1'b0, "R3");
        // R6 video guard, then R4 disparity held across it
        for (int i = 0; i < 2; i++) cyc(2'd1, 24'h123456, 12'h0, 6'h0, 1'b1, "R6");
        for (int i = 0; i < 40; i++)
            cyc(2'd1, {8'(i * 3), 8'(i * 91), 8'(i ^ 8'hA5)}, 12'h0, 6'h0, 1'b0, "R4");
        // R4 disparity restarts after a control cycle
        cyc(2'd0, 24'h0, 12'h0, 6'h1B, 1'b0, "R4");
        for (int i = 0; i < 20; i++)
            cyc(2'd1, {8'(i + 200), 8'(i * 5), 8'(8'hF0 >> (i % 8))}, 12'h0, 6'h0, 1'b0, "R4");
        // R5 island sweep
        cyc(2'd0, 24'h0, 12'h0, 6'h0, 1'b0, "R2");
        for (int i = 0; i < 16; i++)
            cyc(2'd2, 24'h0, {4'(i ^ 5), 4'(15 - i), 4'(i)}, 6'h0, 1'b0, "R5");
        for (int i = 0; i < 2; i++) cyc(2'd2, 24'h0, 12'h7A1, 6'h0, 1'b1, "R6");
        for (int i = 0; i < 16; i++)
            cyc(2'd2, 24'h0, {4'(i * 7), 4'(i + 3), 4'(15 - i)}, 6'h0, 1'b0, "R5");
        // R7 guard ignored in control
        for (int i = 0; i < 4; i++) cyc(2'd0, 24'h0, 12'h0, 6'(i * 9 + 2), 1'b1, "R7");
        // R10 single video cycle between control cycles
        cyc(2'd1, 24'h00FF10, 12'h0, 6'h0, 1'b0, "R10");
        cyc(2'd0, 24'h0, 12'h0, 6'h2D, 1'b0, "R10");
        cyc(2'd0, 24'h0, 12'h0, 6'h12, 1'b0, "R10");
        // R8 direct video to island, then island to video
        for (int i = 0; i < 3; i++) cyc(2'd1, 24'(i * 777), 12'h0, 6'h0, 1'b0, "R3");
        cyc(2'd2, 24'h0, 12'hABC, 6'h27, 1'b1, "R8");
        for (int i = 0; i < 3; i++) cyc(2'd2, 24'h0, 12'(i * 291), 6'h0, 1'b0, "R5");
        cyc(2'd1, 24'h55AA33, 12'h0, 6'h39, 1'b0, "R8");
        cyc(2'd1, 24'h010203, 12'h0, 6'h0, 1'b0, "R3");
        for (int i = 0; i < 3; i++) cyc(2'd0, 24'h0, 12'h0, 6'h0, 1'b0, "R8");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule